// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Data Path

This block sits between a peripheral with a 16-bit data path and a big-endian memory system. It takes one transfer request at a time (peripheral address, byte length, direction and a swap enable), forms the memory address by OR-ing the peripheral address with an externally held high-address value, and then moves the data one 16-bit unit per cycle over a valid/ready memory port. Read data goes back to the peripheral on a registered stream. Write data comes from the peripheral on a stream that is consumed as the memory accepts each unit.

With swapping enabled, the start address and the byte length are rounded down to even values, and the two bytes of every 16-bit unit are exchanged in both directions. Swapped writes to memory are also split into bursts of at most `CHUNK_BYTES` bytes, and each burst is announced with a start marker and its byte length. With swapping disabled, the address and length pass through unchanged, and an odd length ends with a unit that carries a single byte. A request that leaves a length of zero finishes without touching memory. A one-cycle done pulse closes every transfer.

Top module: `hws_dma_path`

## Requirements
- R1: While reset is held and after release, `busy`, `done`, `mem_valid` and `rd_valid` are 0 until a request is accepted.
- R2: The first memory address of a transfer is `req_addr | hi_bits`, and each accepted unit advances the address by 2.
- R3: With `req_swap`=0, address and length are used unchanged. Every unit has `mem_be`=2'b11, except a final single-byte unit, which has `mem_be`=2'b10. Bit 1 of `mem_be` marks the byte at the lower address, carried in data bits 15:8.
- R4: With `req_swap`=1, bit 0 of both the address and the length is cleared before the transfer, and every unit has `mem_be`=2'b11.
- R5: For a swapped write, `mem_wdata` is `{wr_data[7:0], wr_data[15:8]}`. For an unswapped write, it equals `wr_data`.
- R6: For a swapped read, `rd_data` is `{mem_rdata[7:0], mem_rdata[15:8]}`. For an unswapped read, it equals `mem_rdata`.
- R7: A swapped write is issued as bursts of `min(remaining, CHUNK_BYTES)` bytes. Any other transfer is a single burst of the whole length. `mem_sob` is 1 on the first unit of each burst, and `mem_blen` holds that burst's byte length.
- R8: A unit moves when `mem_valid` and `mem_ready` are both 1. While the memory stalls, the address holds. `wr_ready` is 1 exactly on write units that move.
- R9: `rd_valid` is 1 in the cycle after each read unit moves, carrying that unit's data and `mem_be`.
- R10: `done` is a one-cycle pulse in the cycle after the last unit moves.
- R11: A request whose length is zero after R3/R4 raises `done` in the cycle after acceptance and issues no memory unit.
- R12: A request presented while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_bits | input | AW | High-address value OR-ed into the request address |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_addr | input | AW | Peripheral byte address |
| req_len | input | LW | Byte length |
| req_write | input | 1 | 1 = write to memory, 0 = read from memory |
| req_swap | input | 1 | Enable halfword alignment and byte exchange |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | input | 1 | Peripheral write data available |
| wr_data | input | 16 | Peripheral write data |
| wr_ready | output | 1 | Write unit consumed |
| rd_valid | output | 1 | Read data to peripheral valid |
| rd_data | output | 16 | Read data to peripheral |
| rd_be | output | 2 | Byte enables of the read unit |
| mem_valid | output | 1 | Memory unit request |
| mem_ready | input | 1 | Memory accepts the unit |
| mem_write | output | 1 | Unit direction |
| mem_addr | output | AW | Unit byte address |
| mem_be | output | 2 | Unit byte enables |
| mem_wdata | output | 16 | Write data to memory |
| mem_rdata | input | 16 | Read data from memory, valid with the handshake |
| mem_sob | output | 1 | First unit of a burst |
| mem_blen | output | LW | Byte length of the current burst |

## Verification
The bench builds the block with `AW`=16, `LW`=10 and `CHUNK_BYTES`=8. The small burst size makes a 20-byte swapped write cross two burst boundaries and end in a short tail burst. It also lets an exactly full single burst and a 20-byte unswapped write, which must stay one burst, be compared within a few dozen cycles. The random stalls on the memory side exercise address hold and the timing of the done pulse against the last moved unit.

// File: rtl/hws_pkg.sv
package hws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_DONE  = 2'd3
  } hws_state_e;

  localparam int unsigned UNIT_W = 16;
  localparam int unsigned BE_W   = 2;

endpackage

// File: rtl/hws_lane_swap.sv
module hws_lane_swap
  import hws_pkg::*;
(
  input  logic [UNIT_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  input  logic              swap_en,
  output logic [UNIT_W-1:0] out_data,
  output logic [BE_W-1:0]   out_be
);

  localparam int unsigned NBYTES = UNIT_W / 8;

  // byte lane k of the output takes lane (NBYTES-1-k) of the input when swapping
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    always_comb begin
      if (swap_en) begin
        out_data[k*8 +: 8] = in_data[(NBYTES-1-k)*8 +: 8];
        out_be[k]          = in_be[NBYTES-1-k];
      end else begin
        out_data[k*8 +: 8] = in_data[k*8 +: 8];
        out_be[k]          = in_be[k];
      end
    end
  end

endmodule

// File: rtl/hws_burst_calc.sv
module hws_burst_calc #(
  parameter int unsigned LW          = 16,
  parameter int unsigned CHUNK_BYTES = 64
) (
  input  logic [LW-1:0] remaining,
  input  logic          chunked,
  output logic [LW-1:0] burst_len
);

  localparam longint unsigned LEN_SPAN = longint'(1) << LW;

  generate
    if (longint'(CHUNK_BYTES) >= LEN_SPAN) begin : g_nolimit
      // no length can exceed the chunk, so the burst always covers the rest
      logic unused_chunked;
      assign unused_chunked = chunked;
      assign burst_len      = remaining;
    end else begin : g_limit
      localparam logic [LW-1:0] CHUNK_L = LW'(CHUNK_BYTES);
      always_comb begin
        if (chunked && (remaining > CHUNK_L)) burst_len = CHUNK_L;
        else                                  burst_len = remaining;
      end
    end
  endgenerate

endmodule

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned LW          = 16,
  parameter int unsigned CHUNK_BYTES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   hi_bits,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [LW-1:0]   req_len,
  input  logic            req_write,
  input  logic            req_swap,
  input  logic            wr_valid,
  input  logic            mem_ready,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_valid_o,
  output logic            mem_write_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [BE_W-1:0] mem_be_o,
  output logic            mem_sob_o,
  output logic [LW-1:0]   mem_blen_o,
  output logic            swap_o,
  output logic            beat_o
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(2);
  localparam logic [LW-1:0] LEN_ONE   = LW'(1);
  localparam logic [LW-1:0] LEN_TWO   = LW'(2);
  localparam logic [LW-1:0] CHUNK_CAP = (longint'(CHUNK_BYTES) >= (longint'(1) << LW))
                                        ? {LW{1'b1}} : LW'(CHUNK_BYTES);

  hws_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic [LW-1:0] bleft_q, bleft_d;
  logic [LW-1:0] blen_q, blen_d;
  logic          write_q, write_d;
  logic          swap_q, swap_d;
  logic          sob_q, sob_d;
  logic          dp_en;

  logic [AW-1:0] eff_addr;
  logic [LW-1:0] eff_len;
  logic [LW-1:0] calc_blen;
  logic [LW-1:0] unit_len;
  logic          accept;
  logic          beat;

  hws_burst_calc #(
    .LW          (LW),
    .CHUNK_BYTES (CHUNK_BYTES)
  ) u_burst_calc (
    .remaining (rem_q),
    .chunked   (write_q & swap_q),
    .burst_len (calc_blen)
  );

  // request shaping: OR merge, then even rounding when swapping
  always_comb begin
    eff_addr = req_addr | hi_bits;
    eff_len  = req_len;
    if (req_swap) begin
      eff_addr[0] = 1'b0;
      eff_len[0]  = 1'b0;
    end
  end

  assign accept      = (state_q == ST_IDLE) && req_valid;
  assign mem_valid_o = (state_q == ST_XFER) && (!write_q || wr_valid);
  assign beat        = mem_valid_o && mem_ready;
  assign unit_len    = (rem_q == LEN_ONE) ? LEN_ONE : LEN_TWO;
  assign dp_en       = accept || (state_q == ST_SETUP) || beat;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    bleft_d = bleft_q;
    blen_d  = blen_q;
    write_d = write_q;
    swap_d  = swap_q;
    sob_d   = sob_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          addr_d  = eff_addr;
          rem_d   = eff_len;
          write_d = req_write;
          swap_d  = req_swap;
          state_d = (eff_len == '0) ? ST_DONE : ST_SETUP;
        end
      end
      ST_SETUP: begin
        blen_d  = calc_blen;
        bleft_d = calc_blen;
        sob_d   = 1'b1;
        state_d = ST_XFER;
      end
      ST_XFER: begin
        if (beat) begin
          addr_d  = addr_q + ADDR_STEP;
          rem_d   = rem_q - unit_len;
          bleft_d = bleft_q - unit_len;
          sob_d   = 1'b0;
          if (bleft_q == unit_len) begin
            state_d = (rem_q == unit_len) ? ST_DONE : ST_SETUP;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rem_q   <= '0;
      bleft_q <= '0;
      blen_q  <= '0;
      write_q <= 1'b0;
      swap_q  <= 1'b0;
      sob_q   <= 1'b0;
    end else if (dp_en) begin
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      bleft_q <= bleft_d;
      blen_q  <= blen_d;
      write_q <= write_d;
      swap_q  <= swap_d;
      sob_q   <= sob_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign mem_write_o = write_q;
  assign mem_addr_o  = addr_q;
  assign mem_be_o    = (rem_q == LEN_ONE) ? 2'b10 : 2'b11;
  assign mem_sob_o   = sob_q;
  assign mem_blen_o  = blen_q;
  assign swap_o      = swap_q;
  assign beat_o      = beat;

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready) |=> $stable(addr_q));

  // R4
  even_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && swap_q) |-> (addr_q[0] == 1'b0 && mem_be_o == 2'b11));

  // R7
  chunk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && write_q && swap_q) |-> (blen_q <= CHUNK_CAP && blen_q != '0));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(write_q) && $stable(swap_q)));

endmodule

// File: rtl/hws_dma_path.sv
module hws_dma_path
  import hws_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned LW          = 16,
  parameter int unsigned CHUNK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] hi_bits,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_write,
  input  logic          req_swap,
  output logic          busy,
  output logic          done,
  input  logic          wr_valid,
  input  logic [15:0]   wr_data,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic [1:0]    rd_be,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          mem_sob,
  output logic [LW-1:0] mem_blen
);

  logic              swap_q;
  logic              beat;
  logic              rd_beat;
  logic [UNIT_W-1:0] rd_sw_data;
  logic [BE_W-1:0]   rd_sw_be;
  logic [BE_W-1:0]   wr_sw_be;
  logic              rd_valid_q, rd_valid_d;
  logic [UNIT_W-1:0] rd_data_q;
  logic [BE_W-1:0]   rd_be_q;

  hws_ctrl #(
    .AW          (AW),
    .LW          (LW),
    .CHUNK_BYTES (CHUNK_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hi_bits     (hi_bits),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .req_write   (req_write),
    .req_swap    (req_swap),
    .wr_valid    (wr_valid),
    .mem_ready   (mem_ready),
    .busy_o      (busy),
    .done_o      (done),
    .mem_valid_o (mem_valid),
    .mem_write_o (mem_write),
    .mem_addr_o  (mem_addr),
    .mem_be_o    (mem_be),
    .mem_sob_o   (mem_sob),
    .mem_blen_o  (mem_blen),
    .swap_o      (swap_q),
    .beat_o      (beat)
  );

  // write direction: peripheral to memory
  hws_lane_swap u_wr_swap (
    .in_data  (wr_data),
    .in_be    (2'b11),
    .swap_en  (swap_q),
    .out_data (mem_wdata),
    .out_be   (wr_sw_be)
  );

  // read direction: memory to peripheral
  hws_lane_swap u_rd_swap (
    .in_data  (mem_rdata),
    .in_be    (mem_be),
    .swap_en  (swap_q),
    .out_data (rd_sw_data),
    .out_be   (rd_sw_be)
  );

  assign wr_ready   = beat && mem_write && (wr_sw_be == 2'b11);
  assign rd_beat    = beat && !mem_write;
  assign rd_valid_d = rd_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      rd_be_q   <= '0;
    end else if (rd_beat) begin
      rd_data_q <= rd_sw_data;
      rd_be_q   <= swap_q ? rd_sw_be : mem_be;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign rd_be    = rd_be_q;

  // R9
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> $past(mem_valid && mem_ready && !mem_write));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !done));

endmodule

// File: tb/hws_dma_path_bench.sv
module hws_dma_path_bench;

  localparam int unsigned AW = 16;
  localparam int unsigned LW = 10;
  localparam int unsigned CB = 8;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          wr;
    logic [15:0]   wdata;
    logic [1:0]    be;
    logic          sob;
    logic [LW-1:0] blen;
  } beat_t;

  typedef struct packed {
    logic [15:0] data;
    logic [1:0]  be;
  } rd_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] hi_bits = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_write = 1'b0;
  logic          req_swap = 1'b0;
  logic          busy, done;
  logic          wr_valid = 1'b1;
  logic [15:0]   wr_data;
  logic          wr_ready;
  logic          rd_valid;
  logic [15:0]   rd_data;
  logic [1:0]    rd_be;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic          mem_write;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata;
  logic          mem_sob;
  logic [LW-1:0] mem_blen;

  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  int   last_beat_cyc = 0;
  int   rdy_random = 0;
  logic [7:0]  lfsr = 8'hA5;
  logic [15:0] wk = '0;

  beat_t exp_beats[$];
  rd_t   exp_rds[$];

  always #2 clk = ~clk;

  hws_dma_path #(.AW(AW), .LW(LW), .CHUNK_BYTES(CB)) u_hws_dma_path (
    .clk(clk), .rst_n(rst_n), .hi_bits(hi_bits),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .req_write(req_write), .req_swap(req_swap),
    .busy(busy), .done(done),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_be(rd_be),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_sob(mem_sob), .mem_blen(mem_blen)
  );

  function automatic logic [15:0] mem_model(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'h11};
  endfunction

  function automatic logic [15:0] src_word(input logic [15:0] k);
    return {k[7:0], ~k[7:0]};
  endfunction

  assign mem_rdata = mem_model(mem_addr);
  assign wr_data   = src_word(wk);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_ready) wk <= wk + 16'd1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  always @(posedge clk) begin
    #1;
    mem_ready <= (rdy_random != 0) ? lfsr[0] | lfsr[3] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready) begin
        last_beat_cyc = cyc;
        if (exp_beats.size() == 0) begin
          chk(1'b0, "R12 unexpected memory unit", 64'(mem_addr), 64'hFFFF);
        end else begin
          beat_t e;
          beat_t a;
          e = exp_beats.pop_front();
          a.addr = mem_addr; a.wr = mem_write; a.be = mem_be;
          a.sob = mem_sob; a.blen = mem_blen;
          a.wdata = mem_write ? mem_wdata : 16'h0;
          chk(a.addr == e.addr && a.wr == e.wr && a.be == e.be, "R2/R3/R4 unit address/be",
              64'({a.addr, a.wr, a.be}), 64'({e.addr, e.wr, e.be}));
          chk(a.sob == e.sob && a.blen == e.blen, "R7 burst marker/length",
              64'({a.sob, a.blen}), 64'({e.sob, e.blen}));
          if (e.wr) chk(a.wdata == e.wdata, "R5 write data", 64'(a.wdata), 64'(e.wdata));
          chk(wr_ready == e.wr, "R8 wr_ready on write unit", 64'(wr_ready), 64'(e.wr));
        end
      end
      if (rd_valid) begin
        if (exp_rds.size() == 0) begin
          chk(1'b0, "R9 unexpected rd_valid", 64'(rd_data), 64'h0);
        end else begin
          rd_t r;
          r = exp_rds.pop_front();
          chk(rd_data == r.data && rd_be == r.be, "R6/R9 read data",
              64'({rd_data, rd_be}), 64'({r.data, r.be}));
        end
      end
    end
  end

  // driver: pushes expected units, issues the request, waits for done
  task automatic run_req(input logic [AW-1:0] a, input logic [LW-1:0] l,
                         input logic w, input logic s, input bit poke);
    logic [AW-1:0] ea;
    int            el;
    int            rem;
    int            bleft;
    int            blen;
    int            k;
    int            req_cyc;
    int            waited;
    ea = a | hi_bits;
    el = int'(l);
    if (s) begin
      ea[0] = 1'b0;
      el = el & ~1;
    end
    rem = el;
    k = 0;
    bleft = 0;
    blen = 0;
    while (rem > 0) begin
      beat_t b;
      bit first;
      first = 1'b0;
      if (bleft == 0) begin
        blen = (w && s && rem > CB) ? CB : rem;
        bleft = blen;
        first = 1'b1;
      end
      b.addr = ea + AW'(2 * k);
      b.wr = w;
      b.be = (rem == 1) ? 2'b10 : 2'b11;
      b.sob = first;
      b.blen = LW'(blen);
      b.wdata = s ? {src_word(wk + 16'(k))[7:0], src_word(wk + 16'(k))[15:8]}
                  : src_word(wk + 16'(k));
      if (!w) b.wdata = 16'h0;
      exp_beats.push_back(b);
      if (!w) begin
        rd_t r;
        logic [15:0] m;
        m = mem_model(b.addr);
        r.data = s ? {m[7:0], m[15:8]} : m;
        r.be = b.be;
        exp_rds.push_back(r);
      end
      rem   -= (rem == 1) ? 1 : 2;
      bleft -= (bleft == 1) ? 1 : 2;
      k++;
    end
    @(posedge clk); #1;
    req_addr = a; req_len = l; req_write = w; req_swap = s; req_valid = 1'b1;
    req_cyc = cyc;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (poke) begin
      @(posedge clk); #1;
      req_addr = a ^ AW'(16'h0F00); req_len = LW'(6); req_write = ~w; req_swap = ~s;
      req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!done && waited < 3000);
    chk(done == 1'b1, "R10 done seen", 64'(done), 64'h1);
    if (el == 0) begin
      chk(cyc == req_cyc + 1, "R11 zero length done timing", 64'(cyc), 64'(req_cyc + 1));
    end else begin
      chk(cyc == last_beat_cyc + 1, "R10 done after last unit", 64'(cyc), 64'(last_beat_cyc + 1));
    end
    chk(exp_beats.size() == 0, "R2 all units issued", 64'(exp_beats.size()), 64'h0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R10 done is one cycle", 64'({done, busy}), 64'h0);
    chk(exp_rds.size() == 0, "R9 all reads returned", 64'(exp_rds.size()), 64'h0);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && mem_valid == 1'b0, "R12 no later transfer", 64'({busy, mem_valid}), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_valid && !rd_valid, "R1 reset state",
        64'({busy, done, mem_valid, rd_valid}), 64'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_valid && !rd_valid, "R1 idle after reset",
        64'({busy, done, mem_valid, rd_valid}), 64'h0);

    rdy_random = 1;
    hi_bits = 16'h0100;
    run_req(16'h0011, 10'd21, 1'b1, 1'b1, 1'b0);   // R4 R5 R7 swapped write, 3 bursts
    hi_bits = 16'h0400;
    run_req(16'h0023, 10'd5, 1'b1, 1'b0, 1'b0);    // R3 R5 unswapped odd write
    hi_bits = 16'h0200;
    run_req(16'h0035, 10'd7, 1'b0, 1'b1, 1'b0);    // R4 R6 swapped read
    hi_bits = 16'h0000;
    run_req(16'h0040, 10'd3, 1'b0, 1'b0, 1'b0);    // R3 R6 unswapped odd read
    run_req(16'h0051, 10'd1, 1'b1, 1'b1, 1'b0);    // R11 rounds to zero
    run_req(16'h0000, 10'd0, 1'b0, 1'b0, 1'b0);    // R11 zero read
    hi_bits = 16'h3000;
    run_req(16'h0062, 10'd8, 1'b0, 1'b0, 1'b1);    // R12 request while busy
    run_req(16'h0070, 10'd20, 1'b1, 1'b0, 1'b0);   // R7 unswapped write is one burst
    rdy_random = 0;
    run_req(16'h0081, 10'd8, 1'b1, 1'b1, 1'b0);    // R7 exactly one full burst
    rdy_random = 1;
    run_req(16'h0090, 10'd16, 1'b0, 1'b1, 1'b1);   // R8 R12 stalled swapped read

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule